// File: doc/BRIEF.md
# Serial Bit Clock and Frame Sync Generator

This block derives a serial-port bit clock and a frame sync pulse from one system clock. It has two possible source clocks. One is a timer that divides the system clock by eight times a 32-bit period value, which reaches low bit rates that a short divider cannot. The other is a fixed half-rate internal clock. The selected source can be inverted. An 8-bit divider then turns it into the bit clock. A 12-bit frame counter, counting bit clocks, places the frame sync, and an 8-bit width value sets how many bit clocks the sync stays high.

All logic runs on the system clock. The source and the bit clock are produced as registered levels. A one-cycle enable, `bit_rise`, marks every rising edge of the bit clock, so that downstream logic can stay on the system clock instead of clocking on the derived clock. The configuration inputs are captured during reset and again at every frame boundary, so the output never changes its rate part-way through a frame.

Top module: `serclk_fsync_gen`

## Requirements
- R1: While `rst` is high, `bit_clk`, `bit_rise` and `frm_sync` are low. All counters restart from zero, and the configuration inputs are captured. After `rst` is released, the first bit period starts on the first rising edge of the selected source.
- R2: `bit_rise` is high for exactly one system cycle, in the same cycle as each rising edge of `bit_clk`.
- R3: The bit period is (`bit_div`+1) source periods. When `bit_div` is zero or odd, `bit_clk` is high for exactly half of the period.
- R4: When `bit_div` is even and nonzero, `bit_clk` is high for `bit_div`/2 source periods and low for the rest of the period.
- R5: When `src_internal`=0, the source is the timer. Its period is 8×`tmr_period` system cycles with a 50% duty cycle, and a period value of 0 behaves as 1. When `src_internal`=1, the source has a period of 2 system cycles.
- R6: When `src_invert`=1, the source is inverted before the dividers. With the timer source, this moves the first bit edge after reset 4×`tmr_period` system cycles earlier.
- R7: The frame sync period is (`frame_len`+1) bit periods. `frm_sync` is high for (`sync_width`+1) bit periods.
- R8: `frm_sync` rises only in a cycle in which `bit_rise` is high, which is the first bit of a frame. It also falls only on a `bit_rise` cycle.
- R9: When `sync_width` ≥ `frame_len`, the pulse is cut at the frame length, so `frm_sync` stays high without a break.
- R10: A configuration change takes effect at the next frame boundary. Bits that remain in the current frame keep the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_period | input | 32 | Timer period; timer source period is 8× this value in system cycles |
| src_internal | input | 1 | 0 selects the timer source, 1 selects the half-rate internal source |
| src_invert | input | 1 | Inverts the selected source |
| bit_div | input | 8 | Bit clock divide value minus one |
| frame_len | input | 12 | Frame length in bit periods, minus one |
| sync_width | input | 8 | Frame sync width in bit periods, minus one |
| bit_clk | output | 1 | Bit clock level |
| bit_rise | output | 1 | One-cycle enable on each bit clock rising edge |
| frm_sync | output | 1 | Frame sync |

## Verification
The bit divider is run with a zero, an odd and an even divide value. Together these separate the true 50% case from the floor rule for the high time, and they show whether the divide-by-one path follows the source directly. The timer source is tried with two period values. This shows whether the factor of eight and the divider stack on top of each other, and an inverted run compares the arrival of the first edge to measure the half-period shift. Frame patterns cover three cases: a normal pulse narrower than the frame, a width larger than the frame, which must stay high, and a divide change made mid-frame, which must wait for the boundary.

// File: rtl/serclk_fsync_gen.sv
module serclk_fsync_gen #(
  parameter int PER_W = 32,
  parameter int DIV_W = 8,
  parameter int FRM_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] tmr_period,
  input  logic             src_internal,
  input  logic             src_invert,
  input  logic [DIV_W-1:0] bit_div,
  input  logic [FRM_W-1:0] frame_len,
  input  logic [WID_W-1:0] sync_width,
  output logic             bit_clk,
  output logic             bit_rise,
  output logic             frm_sync
);
  localparam int TC_W  = PER_W + 2;
  localparam int CMP_W = ((FRM_W > WID_W) ? FRM_W : WID_W) + 1;

  logic [PER_W-1:0] a_per;
  logic             a_int, a_inv;
  logic [DIV_W-1:0] a_div;
  logic [FRM_W-1:0] a_frm;
  logic [WID_W-1:0] a_wid;

  logic [TC_W-1:0]  tcnt, t_lim;
  logic             tlvl, ilvl;
  logic             src_sel, src_sel_q, tick;
  logic [DIV_W-1:0] ph;
  logic [DIV_W:0]   hi;
  logic             run, bstart;
  logic [FRM_W-1:0] fc;
  logic             frun, fstart;
  logic             rise_q;

  // timer half period is 4*period system cycles
  assign t_lim = (a_per == '0) ? TC_W'(3) : ({a_per, 2'b00} - TC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
      tlvl <= 1'b0;
      ilvl <= 1'b0;
    end else begin
      ilvl <= ~ilvl;
      if (tcnt >= t_lim) begin
        tcnt <= '0;
        tlvl <= ~tlvl;
      end else begin
        tcnt <= tcnt + TC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel   <= 1'b0;
      src_sel_q <= 1'b0;
    end else begin
      src_sel   <= (a_int ? ilvl : tlvl) ^ a_inv;
      src_sel_q <= src_sel;
    end
  end

  assign tick   = src_sel & ~src_sel_q;
  assign bstart = tick & (~run | (ph == a_div));
  assign fstart = bstart & (~frun | (fc == a_frm));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      run    <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= bstart;
      if (bstart) begin
        ph  <= '0;
        run <= 1'b1;
      end else if (tick) begin
        ph <= ph + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fc   <= '0;
      frun <= 1'b0;
    end else if (fstart) begin
      fc   <= '0;
      frun <= 1'b1;
    end else if (bstart) begin
      fc <= fc + FRM_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || fstart) begin
      a_per <= tmr_period;
      a_int <= src_internal;
      a_inv <= src_invert;
      a_div <= bit_div;
      a_frm <= frame_len;
      a_wid <= sync_width;
    end
  end

  assign hi       = ({1'b0, a_div} + (DIV_W+1)'(1)) >> 1;
  assign bit_clk  = run & ((a_div == '0) ? src_sel_q : ({1'b0, ph} < hi));
  assign bit_rise = rise_q;
  assign frm_sync = frun & (CMP_W'(fc) <= CMP_W'(a_wid));

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bit_clk && !bit_rise && !frm_sync));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    bit_rise |=> !bit_rise);

  a_r2_rise_marked: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_clk) |-> bit_rise);

  a_r8_sync_rise_on_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(frm_sync) |-> bit_rise);

  a_r8_sync_fall_on_bit: assert property (@(posedge clk) disable iff (rst)
    $fell(frm_sync) |-> bit_rise);
endmodule

// File: tb/sim_serclk_fsync_gen.sv
module sim_serclk_fsync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tmr_period = 32'd1;
  logic        src_internal = 1'b1;
  logic        src_invert = 1'b0;
  logic [7:0]  bit_div = 8'd0;
  logic [11:0] frame_len = 12'd0;
  logic [7:0]  sync_width = 8'd0;
  logic        bit_clk, bit_rise, frm_sync;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  serclk_fsync_gen u0 (
    .clk(clk), .rst(rst), .tmr_period(tmr_period), .src_internal(src_internal),
    .src_invert(src_invert), .bit_div(bit_div), .frame_len(frame_len),
    .sync_width(sync_width), .bit_clk(bit_clk), .bit_rise(bit_rise), .frm_sync(frm_sync)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit s_int, input bit s_inv, input int per,
                          input int div, input int flen, input int wid);
    @(negedge clk);
    src_internal = s_int; src_invert = s_inv; tmr_period = per;
    bit_div = div[7:0]; frame_len = flen[11:0]; sync_width = wid[7:0];
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_rise(output int t);
    int k = 0;
    @(negedge clk);
    while (!bit_rise && k < TMO) begin
      @(negedge clk);
      k++;
    end
    if (k >= TMO) check("R2", "bit_rise timeout", 0, 1);
    t = cyc;
  endtask

  task automatic measure_bit(output int per, output int hi);
    per = 0; hi = 0;
    do begin
      hi += int'(bit_clk);
      per++;
      @(negedge clk);
    end while (!bit_rise && per < TMO);
  endtask

  task automatic wait_sync_high();
    int k = 0;
    while (!frm_sync && k < TMO) begin
      @(negedge clk);
      k++;
    end
    if (k >= TMO) check("R7", "frm_sync timeout", 0, 1);
  endtask

  task automatic measure_frame(output int per, output int hi);
    bit seen_low = 1'b0;
    per = 0; hi = 0;
    do begin
      hi += int'(frm_sync);
      per++;
      @(negedge clk);
      if (!frm_sync) seen_low = 1'b1;
    end while (!(frm_sync && seen_low) && per < TMO);
  endtask

  task automatic t_reset();
    int t;
    do_reset(1'b1, 1'b0, 1, 1, 3, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "bit_clk in reset", int'(bit_clk), 0);
    check("R1", "bit_rise in reset", int'(bit_rise), 0);
    check("R1", "frm_sync in reset", int'(frm_sync), 0);
    rst = 1'b0;
    t = cyc;
    wait_rise(t);
    check("R1", "first bit_rise arrives", int'(bit_rise), 1);
  endtask

  task automatic t_bits(input string req, input bit s_int, input int per_v,
                        input int div, input int exp_per, input int exp_hi);
    int t, p, h;
    do_reset(s_int, 1'b0, per_v, div, 0, 0);
    wait_rise(t);
    wait_rise(t);
    measure_bit(p, h);
    check(req, "bit period", p, exp_per);
    check(req, "bit high time", h, exp_hi);
    check("R2", "bit_rise at period end", int'(bit_rise), 1);
  endtask

  task automatic t_invert();
    int t0, t1, d_plain, d_inv;
    do_reset(1'b0, 1'b0, 2, 0, 0, 0);
    t0 = cyc;
    wait_rise(t1);
    d_plain = t1 - t0;
    do_reset(1'b0, 1'b1, 2, 0, 0, 0);
    t0 = cyc;
    wait_rise(t1);
    d_inv = t1 - t0;
    check("R6", "first edge shift by inversion", d_plain - d_inv, 8);
  endtask

  task automatic t_frame();
    int p, h;
    do_reset(1'b1, 1'b0, 1, 1, 4, 1);
    wait_sync_high();
    check("R8", "bit_rise at sync rise", int'(bit_rise), 1);
    measure_frame(p, h);
    check("R7", "frame period", p, 20);
    check("R7", "sync width", h, 8);
    check("R8", "bit_rise at next sync rise", int'(bit_rise), 1);
    measure_frame(p, h);
    check("R7", "second frame period", p, 20);
  endtask

  task automatic t_trunc();
    int lows = 0;
    do_reset(1'b1, 1'b0, 1, 0, 2, 9);
    wait_sync_high();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!frm_sync) lows++;
    end
    check("R9", "sync low cycles with wide pulse", lows, 0);
  endtask

  task automatic t_cfg_change();
    int t0, t1, t2, t3, t4, t5, s4;
    do_reset(1'b1, 1'b0, 1, 1, 3, 0);
    @(negedge clk);
    while (frm_sync) @(negedge clk);
    wait_sync_high();
    t0 = cyc;
    bit_div = 8'd3;
    wait_rise(t1);
    check("R10", "bit period before boundary", t1 - t0, 4);
    wait_rise(t2);
    wait_rise(t3);
    check("R10", "last old bit period", t3 - t2, 4);
    wait_rise(t4);
    s4 = int'(frm_sync);
    check("R10", "sync at boundary", s4, 1);
    wait_rise(t5);
    check("R10", "bit period after boundary", t5 - t4, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bits("R3", 1'b1, 1, 3, 8, 4);
    t_bits("R3", 1'b1, 1, 0, 2, 1);
    t_bits("R4", 1'b1, 1, 4, 10, 4);
    t_bits("R4", 1'b1, 1, 2, 6, 2);
    t_bits("R5", 1'b0, 1, 0, 8, 4);
    t_bits("R5", 1'b0, 3, 1, 48, 24);
    t_bits("R5", 1'b0, 0, 0, 8, 4);
    t_invert();
    t_frame();
    t_trunc();
    t_cfg_change();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule